// File: doc/BRIEF.md
# Dual-Style Host Bus Slave Port

This block is the slave side of a host processor bus. It lets a host reach a small bank of 8-bit registers. Two static strap inputs choose how the host talks to it. One strap picks the control style: address-strobe/data-strobe with a read/write level and an active-low acknowledge, or address-latch with separate active-low read and write strobes and a ready output. The other strap picks the addressing: a separate 4-bit address beside the 8-bit data bus, or a shared 8-bit address/data bus.

The host control pins pass through a two-flop synchronizer into the internal clock domain. Both control styles reduce to one internal read request and one internal write request. Each accepted access gives exactly one single-cycle read or write strobe on the register side. In the shared-bus modes the low address nibble is latched on the falling edge of the address strobe. The high nibble is compared with a device number, so several copies can share one bus and only the addressed copy answers. Device number and wait-state count live in a local register at address 4, which is the only register with a reset value. A programmable number of extra clock cycles (0 to 3) can be inserted before the acknowledge, so that fast hosts are held off. The data bus is split into an input, an output and an output enable; the enable stands for the tri-state driver and is high only while read data is presented.

Top module: `hostbus_port`

## Requirements
- R1: With cfg_latch_style=0 the acknowledge is dtack_n (low when acknowledged) and rdy stays 1. With cfg_latch_style=1 the handshake is rdy (0 while the access is held off) and dtack_n stays 1.
- R2: A read is cs_n=0 with ds_n=0 and rw=1 (strobe style), or cs_n=0 with rd_n=0 (latch style). Each selected read of an address other than 4 gives exactly one single-cycle reg_rd pulse with reg_addr equal to the access address.
- R3: A write is cs_n=0 with ds_n=0 and rw=0, or cs_n=0 with wr_n=0. Each selected write of an address other than 4 gives exactly one single-cycle reg_wr pulse, with reg_addr equal to the address and reg_wdata equal to ad_i. reg_rd and reg_wr are never high together.
- R4: With cfg_muxed=0 the address is taken from addr_i; ad_i[7:4] does not matter and every access is selected.
- R5: With cfg_muxed=1 the address is ad_i[3:0], latched on the synchronized falling edge of addr_strobe. The access is selected only if the latched ad_i[7:4] equals local register bits [3:0]. An unselected access gives no strobe and no acknowledge, and ad_oe stays 0.
- R6: Address 4 is a local register: bits [3:0] device number, bits [5:4] wait count. It resets to 0x00. Writes update it, reads return it, and neither produces reg_rd or reg_wr.
- R7: With wait count w, the acknowledge (dtack_n low, or rdy back to 1) first appears on the (4+w)-th rising clock edge after the control inputs become active. In latch style rdy is 0 from the 3rd of those edges until then.
- R8: The acknowledge is held until the control inputs go inactive. It is removed on the 3rd rising edge after that.
- R9: ad_oe is 1 only while a selected read is acknowledged. During that time ad_o holds the read value: reg_rdata for external addresses, the local register for address 4.
- R10: After reset dtack_n=1, rdy=1, ad_oe=0, and reg_rd=reg_wr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_latch_style | input | 1 | Strap: 0 strobe/acknowledge style, 1 latch/ready style |
| cfg_muxed | input | 1 | Strap: 0 separate address, 1 shared address/data bus |
| cs_n | input | 1 | Chip select, active low |
| addr_strobe | input | 1 | Address strobe or latch enable; falling edge latches the address in shared mode |
| ds_n | input | 1 | Data strobe, active low (strobe style) |
| rw | input | 1 | 1 read, 0 write (strobe style) |
| rd_n | input | 1 | Read strobe, active low (latch style) |
| wr_n | input | 1 | Write strobe, active low (latch style) |
| addr_i | input | 4 | Separate address bus |
| ad_i | input | 8 | Data bus input (address and data in shared mode) |
| ad_o | output | 8 | Data bus output value |
| ad_oe | output | 1 | Data bus driver enable; 0 means high impedance |
| dtack_n | output | 1 | Data acknowledge, active low |
| rdy | output | 1 | Ready, high when the access may complete |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
Directed accesses cover all four strap combinations. They include a reset-value read of the local register, and a write to it that changes device number and wait count so the next access shows the longer latency. A shared-bus access with the wrong device number must stay silent. Random accesses then mix style, addressing, direction, address and data, with address 4 and mismatching device numbers over-weighted. Each access is checked edge by edge against the expected acknowledge waveform, for the strobe count and address/data, for the read value, and for the release timing. This separates a wrong wait count, a wrong style mapping, a wrong address source and a broken device match.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DO   = 2'd2,
    ST_ACK  = 2'd3
  } hb_state_e;

  // Read request in either control style (all inputs already synchronized)
  function automatic logic f_rd_req(input logic latch_style, input logic cs_n,
                                    input logic ds_n, input logic rw, input logic rd_n);
    if (latch_style) return !cs_n && !rd_n;
    else             return !cs_n && !ds_n && rw;
  endfunction

  // Write request in either control style
  function automatic logic f_wr_req(input logic latch_style, input logic cs_n,
                                    input logic ds_n, input logic rw, input logic wr_n);
    if (latch_style) return !cs_n && !wr_n;
    else             return !cs_n && !ds_n && !rw;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_addr_cap.sv
module hb_addr_cap #(
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int IDW = DW - AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe_s,
  input  logic [DW-1:0]  ad_i,
  input  logic [IDW-1:0] dev_id,
  output logic [AW-1:0]  mux_addr,
  output logic           mux_hit
);
  logic strobe_prev;
  logic strobe_fall;

  assign strobe_fall = strobe_prev && !strobe_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b0;
      mux_addr    <= '0;
      mux_hit     <= 1'b0;
    end else begin
      strobe_prev <= strobe_s;
      if (strobe_fall) begin
        mux_addr <= ad_i[AW-1:0];
        mux_hit  <= (ad_i[DW-1:AW] == dev_id);
      end
    end
  end
endmodule

// File: rtl/hb_seq.sv
module hb_seq
  import hostbus_pkg::*;
#(
  parameter int            AW         = 4,
  parameter int            DW         = 8,
  parameter int            CW         = 2,
  parameter int            LOCAL_ADDR = 4,
  parameter logic [DW-1:0] REG4_RST   = '0,
  localparam int IDW = DW - AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_req,
  input  logic           wr_req,
  input  logic           sel,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata_in,
  input  logic [DW-1:0]  ext_rdata,
  output logic           reg_rd,
  output logic           reg_wr,
  output logic [AW-1:0]  reg_addr,
  output logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  rd_q,
  output logic           busy,
  output logic           acked,
  output logic           rd_phase,
  output logic           local_evt,
  output logic [IDW-1:0] dev_id
);
  localparam logic [AW-1:0] LOC = AW'(LOCAL_ADDR);

  hb_state_e     state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          is_rd_q;
  logic [DW-1:0] reg4;
  logic [CW-1:0] wait_cnt;
  logic          access;
  logic          is_local;

  assign access   = rd_req || wr_req;
  assign dev_id   = reg4[IDW-1:0];
  assign wait_cnt = reg4[IDW +: CW];
  assign is_local = (addr_q == LOC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      is_rd_q <= 1'b0;
      rd_q    <= '0;
      reg4    <= REG4_RST;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (access && sel) begin
            addr_q  <= addr;
            wdata_q <= wdata_in;
            is_rd_q <= rd_req;
            cnt     <= wait_cnt;
            state   <= (wait_cnt == '0) ? ST_DO : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == CW'(1)) state <= ST_DO;
          cnt <= cnt - 1'b1;
        end
        ST_DO: begin
          if (is_rd_q) rd_q <= is_local ? reg4 : ext_rdata;
          else if (is_local) reg4 <= wdata_q;
          state <= ST_ACK;
        end
        ST_ACK: begin
          if (!access) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reg_rd    = (state == ST_DO) && is_rd_q && !is_local;
  assign reg_wr    = (state == ST_DO) && !is_rd_q && !is_local;
  assign local_evt = (state == ST_DO) && is_local;
  assign busy      = (state == ST_WAIT) || (state == ST_DO);
  assign acked     = (state == ST_ACK);
  assign rd_phase  = (state == ST_ACK) && is_rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
  import hostbus_pkg::*;
#(
  parameter int            AW          = 4,
  parameter int            DW          = 8,
  parameter int            CW          = 2,
  parameter int            SYNC_STAGES = 2,
  parameter int            LOCAL_ADDR  = 4,
  parameter logic [DW-1:0] REG4_RST    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_latch_style,
  input  logic          cfg_muxed,
  input  logic          cs_n,
  input  logic          addr_strobe,
  input  logic          ds_n,
  input  logic          rw,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          dtack_n,
  output logic          rdy,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int IDW = DW - AW;
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] ctl_raw, ctl_s;
  logic cs_s, as_s, ds_s, rw_s, rd_s, wr_s;
  logic rd_req, wr_req;
  logic [AW-1:0]  mux_addr, addr_src;
  logic           mux_hit, dev_sel;
  logic [IDW-1:0] dev_id;
  logic [DW-1:0]  rd_q;
  logic busy, acked, rd_phase, local_evt;
  logic strobe_evt;

  assign ctl_raw = {addr_strobe, rw, rd_n, wr_n, ds_n, cs_n};

  hb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(6'b011111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  assign {as_s, rw_s, rd_s, wr_s, ds_s, cs_s} = ctl_s;

  assign rd_req = f_rd_req(cfg_latch_style, cs_s, ds_s, rw_s, rd_s);
  assign wr_req = f_wr_req(cfg_latch_style, cs_s, ds_s, rw_s, wr_s);

  hb_addr_cap #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe_s(as_s), .ad_i(ad_i),
    .dev_id(dev_id), .mux_addr(mux_addr), .mux_hit(mux_hit)
  );

  assign addr_src = cfg_muxed ? mux_addr : addr_i;
  assign dev_sel  = cfg_muxed ? mux_hit  : 1'b1;

  hb_seq #(.AW(AW), .DW(DW), .CW(CW), .LOCAL_ADDR(LOCAL_ADDR), .REG4_RST(REG4_RST)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .sel(dev_sel),
    .addr(addr_src), .wdata_in(ad_i), .ext_rdata(reg_rdata),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_q(rd_q), .busy(busy), .acked(acked), .rd_phase(rd_phase),
    .local_evt(local_evt), .dev_id(dev_id)
  );

  assign strobe_evt = reg_rd || reg_wr || local_evt;

  assign dtack_n = cfg_latch_style ? 1'b1 : !acked;
  assign rdy     = cfg_latch_style ? !busy : 1'b1;
  assign ad_o    = rd_q;
  assign ad_oe   = rd_phase;
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int LOCAL_ADDR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_latch_style,
  input logic          dtack_n,
  input logic          rdy,
  input logic          ad_oe,
  input logic [DW-1:0] ad_o,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          strobe_evt
);
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R2
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R3
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd && reg_wr)); // R3
  AST_STROBE_STYLE_PIN: assert property (@(posedge clk) disable iff (!rst_n) cfg_latch_style |-> dtack_n); // R1
  AST_LATCH_STYLE_PIN: assert property (@(posedge clk) disable iff (!rst_n) !cfg_latch_style |-> rdy); // R1
  AST_DTACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_latch_style && $fell(dtack_n)) |-> $past(strobe_evt)); // R7
  AST_RDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latch_style && $rose(rdy)) |-> $past(strobe_evt)); // R7
  AST_OE_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (cfg_latch_style ? rdy : !dtack_n)); // R9
  AST_OE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $past(ad_oe)) |-> $stable(ad_o)); // R9
  AST_LOCAL_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || reg_wr) |-> (reg_addr != AW'(LOCAL_ADDR))); // R6
endmodule

bind hostbus_port hostbus_port_chk #(.AW(AW), .DW(DW), .LOCAL_ADDR(LOCAL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_latch_style(cfg_latch_style), .dtack_n(dtack_n),
  .rdy(rdy), .ad_oe(ad_oe), .ad_o(ad_o), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .strobe_evt(strobe_evt)
);

// File: tb/hostbus_port_tb_top.sv
module hostbus_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_latch_style, cfg_muxed;
  logic cs_n, addr_strobe, ds_n, rw, rd_n, wr_n;
  logic [3:0] addr_i;
  logic [7:0] ad_i, ad_o, reg_wdata, reg_rdata;
  logic ad_oe, dtack_n, rdy, reg_rd, reg_wr;
  logic [3:0] reg_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [3:0] seen_addr;
  logic [7:0] seen_wdata;
  logic [7:0] model_r4;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbus_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_latch_style(cfg_latch_style), .cfg_muxed(cfg_muxed),
    .cs_n(cs_n), .addr_strobe(addr_strobe), .ds_n(ds_n), .rw(rw), .rd_n(rd_n), .wr_n(wr_n),
    .addr_i(addr_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .dtack_n(dtack_n), .rdy(rdy),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] ext_val(input logic [3:0] a);
    return {a ^ 4'hC, ~a};
  endfunction

  assign reg_rdata = ext_val(reg_addr);

  always @(negedge clk) begin
    if (reg_rd) begin rd_cnt++; seen_addr = reg_addr; end
    if (reg_wr) begin wr_cnt++; seen_addr = reg_addr; seen_wdata = reg_wdata; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_pins();
    cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr_strobe = 1'b0;
  endtask

  task automatic do_access(input bit latch, input bit muxed, input bit is_rd,
                           input logic [3:0] a, input logic [3:0] dev, input logic [7:0] d);
    bit sel;
    int w, tot, bad_edge;
    logic [7:0] exp_rd;
    @(negedge clk);
    cfg_latch_style = latch; cfg_muxed = muxed;
    sel    = !muxed || (dev == model_r4[3:0]);
    w      = int'(model_r4[5:4]);
    tot    = 4 + w;
    exp_rd = (a == 4'd4) ? model_r4 : ext_val(a);
    rd_cnt = 0; wr_cnt = 0;
    if (muxed) begin
      addr_i = ~a;                       // R4: ignored in shared mode
      ad_i = {dev, a}; addr_strobe = 1'b1;
      repeat (3) @(negedge clk);
      addr_strobe = 1'b0;
      repeat (4) @(negedge clk);
      ad_i = is_rd ? 8'($urandom) : d;
    end else begin
      addr_i = a;
      ad_i = is_rd ? 8'($urandom) : d;
      ad_i[7:4] = is_rd ? ad_i[7:4] : d[7:4];
    end
    cs_n = 1'b0;
    if (latch) begin rd_n = !is_rd; wr_n = is_rd; end
    else begin rw = is_rd; ds_n = 1'b0; end
    if (sel) begin
      bad_edge = 0;
      for (int n = 1; n <= tot; n++) begin
        logic e_dt, e_rdy;
        @(posedge clk); #1;
        e_dt  = latch ? 1'b1 : ((n < tot) ? 1'b1 : 1'b0);
        e_rdy = latch ? ((n >= 3 && n < tot) ? 1'b0 : 1'b1) : 1'b1;
        if (bad_edge == 0 && (dtack_n !== e_dt || rdy !== e_rdy)) bad_edge = n;
      end
      chk(bad_edge == 0, "R7", "handshake waveform (first bad edge)", bad_edge, 0);
      chk(latch ? (dtack_n === 1'b1) : (rdy === 1'b1), "R1", "unused handshake pin",
          latch ? dtack_n : rdy, 1);
      if (is_rd) begin
        chk(ad_oe === 1'b1, "R9", "ad_oe during read ack", ad_oe, 1);
        chk(ad_o === exp_rd, "R9", "read data", ad_o, exp_rd);
      end else begin
        chk(ad_oe === 1'b0, "R9", "ad_oe during write", ad_oe, 0);
      end
      @(negedge clk);
      idle_pins();
      for (int m = 1; m <= 3; m++) begin
        logic held;
        @(posedge clk); #1;
        held = latch ? 1'b1 : !dtack_n;
        if (!latch) chk(held === (m < 3), "R8", "ack release timing", held, (m < 3));
      end
      chk(ad_oe === 1'b0, "R9", "ad_oe after release", ad_oe, 0);
      @(negedge clk);
      if (a == 4'd4) begin
        chk(rd_cnt == 0 && wr_cnt == 0, "R6", "local access strobes", rd_cnt + wr_cnt, 0);
        if (!is_rd) model_r4 = d;
      end else if (is_rd) begin
        chk(rd_cnt == 1 && wr_cnt == 0, "R2", "read strobe count", rd_cnt * 16 + wr_cnt, 16);
        chk(seen_addr === a, muxed ? "R5" : "R4", "read address", seen_addr, a);
      end else begin
        chk(wr_cnt == 1 && rd_cnt == 0, "R3", "write strobe count", wr_cnt * 16 + rd_cnt, 16);
        chk(seen_addr === a, muxed ? "R5" : "R4", "write address", seen_addr, a);
        chk(seen_wdata === d, "R3", "write data", seen_wdata, d);
      end
    end else begin
      bit quiet = 1'b1;
      for (int n = 1; n <= 10; n++) begin
        @(posedge clk); #1;
        if (dtack_n !== 1'b1 || rdy !== 1'b1 || ad_oe !== 1'b0) quiet = 1'b0;
      end
      @(negedge clk);
      idle_pins();
      repeat (4) @(negedge clk);
      chk(quiet && rd_cnt == 0 && wr_cnt == 0, "R5", "unselected access silent",
          rd_cnt + wr_cnt, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7689));
    rst_n = 1'b0; cfg_latch_style = 1'b0; cfg_muxed = 1'b0;
    idle_pins(); addr_i = '0; ad_i = '0;
    model_r4 = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dtack_n === 1'b1 && rdy === 1'b1, "R10", "handshake after reset", {dtack_n, rdy}, 3);
    chk(ad_oe === 1'b0 && reg_rd === 1'b0 && reg_wr === 1'b0, "R10", "oe/strobes after reset",
        {ad_oe, reg_rd, reg_wr}, 0);

    // R6 reset value of local register, then program id 5 and wait 2
    do_access(1'b0, 1'b0, 1'b1, 4'd4, 4'h0, 8'h00);
    do_access(1'b0, 1'b0, 1'b0, 4'd4, 4'h0, 8'h25);
    do_access(1'b0, 1'b0, 1'b1, 4'd3, 4'h0, 8'h00);   // R7 latency with w=2
    // R5 shared bus, matching and mismatching device
    do_access(1'b0, 1'b1, 1'b0, 4'd9, 4'h5, 8'hA7);
    do_access(1'b0, 1'b1, 1'b1, 4'd9, 4'h6, 8'h00);
    // latch style, both addressings
    do_access(1'b1, 1'b1, 1'b1, 4'd12, 4'h5, 8'h00);
    do_access(1'b1, 1'b0, 1'b0, 4'd1, 4'hF, 8'h3C);
    do_access(1'b1, 1'b0, 1'b0, 4'd4, 4'h0, 8'h30);   // wait 3, id 0
    do_access(1'b1, 1'b1, 1'b1, 4'd4, 4'h0, 8'h00);
    do_access(1'b0, 1'b0, 1'b0, 4'd4, 4'h0, 8'h00);   // wait 0 again

    for (int k = 0; k < 250; k++) begin
      bit lt = 1'($urandom), mx = 1'($urandom), rd = 1'($urandom);
      logic [3:0] a = ($urandom % 5 == 0) ? 4'd4 : 4'($urandom);
      logic [3:0] dv = ($urandom % 5 == 0) ? (model_r4[3:0] ^ 4'(1 + $urandom % 15))
                                           : model_r4[3:0];
      do_access(lt, mx, rd, a, dv, 8'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule